// File: doc/BRIEF.md
# Modbus RTU Read Request Framer

This block assembles the eight-byte request that a bus master sends to read a run of holding registers from one slave. A single-cycle start strobe captures four fields: the slave address, the function code, the first register address and the register count. The block then hands the frame, one byte per handshake, to a downstream serial transmitter over a valid/ready interface.

The two 16-bit fields leave most significant byte first. A CRC-16 runs alongside the first six bytes. It starts at 0xFFFF, uses the reflected polynomial 0xA001 and advances by one whole byte per accepted handshake. The CRC is appended low byte first. One cycle after the last byte is accepted, a single-cycle done pulse marks the end of the frame. The transmitter, retries and reply timeouts belong to other blocks.

Top module: `mbf_read_framer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, outValid and frameDone are both 0.
- R2: A start pulse sampled while idle raises outValid in the next cycle. The byte order is slave address first, then function code, then address high, address low, count high and count low.
- R3: Both 16-bit fields go out high byte first. The address high byte is byte 2 and the address low byte is byte 3.
- R4: The CRC starts at 0xFFFF. Each byte is XORed into the low 8 bits, followed by 8 right shifts, with XOR of 0xA001 after every shift that drops a 1. For slave 0x02, function 0x03, address 0x0010 and count 0x0003, the CRC after six bytes is 0x3D04.
- R5: Byte 6 is the CRC low byte and byte 7 is the CRC high byte, so the frame has eight bytes. For the example in R4 the frame is 02 03 00 10 00 03 04 3D.
- R6: While outValid is 1 and outReady is 0, outValid stays 1 and outData stays unchanged in the next cycle.
- R7: frameDone is 1 for exactly one cycle, the cycle right after the eighth byte is accepted. outValid is 0 in that cycle.
- R8: A start pulse while a frame is in progress is ignored. The frame in flight finishes with the fields captured at its own start.
- R9: With outReady held at 1, one byte is accepted every cycle, so the eight bytes take eight consecutive cycles.
- R10: The count field is a register count and is sent exactly as given, with no scaling to bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to build a frame |
| slaveId | input | 8 | Target slave address |
| funcCode | input | 8 | Function code |
| startAddr | input | 16 | First register address |
| regCount | input | 16 | Number of registers to read |
| outData | output | 8 | Current frame byte |
| outValid | output | 1 | outData holds a byte to send |
| outReady | input | 1 | Downstream takes the byte at this edge |
| frameDone | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The first byte appears one edge after start is sampled, so the bench checks outValid and the slave address at the following falling edge. Each later byte is counted as accepted at the falling edge where valid and ready are both seen, because the transfer completes at the next rising edge. frameDone is due at the falling edge after the eighth acceptance and must be gone one cycle later. The bench drives and samples only at falling edges, so each result is read one full register stage after its cause. It compares against its own bit-serial CRC model and also against the fixed example frame.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int FRAME_BYTES = 8;
  localparam int SEL_W = $clog2(FRAME_BYTES);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(FRAME_BYTES - 1);
  localparam logic [SEL_W-1:0] CRC_LO_SEL = SEL_W'(FRAME_BYTES - 2);

  typedef struct packed {
    logic load;              // capture fields and seed the CRC
    logic step;              // fold the current byte into the CRC
    logic [SEL_W-1:0] sel;   // which frame byte is presented
  } mbfCtrl_t;

  function automatic logic [15:0] crcUpdate(input logic [15:0] cur,
                                            input logic [7:0] dat,
                                            input logic [15:0] poly);
    logic [15:0] r;
    r = cur ^ {8'h00, dat};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/mbf_control.sv
module mbf_control
  import mbf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     outReady,
  output logic     outValid,
  output logic     frameDone,
  output mbfCtrl_t ctrl
);
  logic busy;
  logic [SEL_W-1:0] idx;
  logic doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      idx     <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx  <= '0;
        end
      end else if (outReady) begin
        if (idx == LAST_SEL) begin
          busy    <= 1'b0;
          doneReg <= 1'b1;
        end else begin
          idx <= idx + SEL_W'(1);
        end
      end
    end
  end

  always_comb begin
    ctrl.load = !busy && start;
    ctrl.step = busy && outReady && (idx < CRC_LO_SEL);
    ctrl.sel  = idx;
  end

  assign outValid  = busy;
  assign frameDone = doneReg;

  AST_START_TO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && start) |=> (outValid && ctrl.sel == '0)); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && ctrl.sel == LAST_SEL) |=> (frameDone && !outValid)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && start && !(outReady && ctrl.sel == LAST_SEL)) |=> outValid); // R8
  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && ctrl.sel != LAST_SEL) |=> (outValid && ctrl.sel == $past(ctrl.sel) + SEL_W'(1))); // R9
endmodule

// File: rtl/mbf_datapath.sv
module mbf_datapath
  import mbf_pkg::*;
#(
  parameter logic [15:0] CRC_SEED = 16'hFFFF,
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic        clk,
  input  logic        rstN,
  input  mbfCtrl_t    ctrl,
  input  logic [7:0]  slaveId,
  input  logic [7:0]  funcCode,
  input  logic [15:0] startAddr,
  input  logic [15:0] regCount,
  output logic [7:0]  outData
);
  logic [7:0]  idReg;
  logic [7:0]  fcReg;
  logic [15:0] addrReg;
  logic [15:0] cntReg;
  logic [15:0] crcReg;
  logic [7:0]  curByte;

  always_comb begin
    case (ctrl.sel)
      SEL_W'(0): curByte = idReg;
      SEL_W'(1): curByte = fcReg;
      SEL_W'(2): curByte = addrReg[15:8];
      SEL_W'(3): curByte = addrReg[7:0];
      SEL_W'(4): curByte = cntReg[15:8];
      SEL_W'(5): curByte = cntReg[7:0];
      SEL_W'(6): curByte = crcReg[7:0];
      default:   curByte = crcReg[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg   <= '0;
      fcReg   <= '0;
      addrReg <= '0;
      cntReg  <= '0;
      crcReg  <= CRC_SEED;
    end else if (ctrl.load) begin
      idReg   <= slaveId;
      fcReg   <= funcCode;
      addrReg <= startAddr;
      cntReg  <= regCount;
      crcReg  <= CRC_SEED;
    end else if (ctrl.step) begin
      crcReg  <= crcUpdate(crcReg, curByte, CRC_POLY);
    end
  end

  assign outData = curByte;

  AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (crcReg == CRC_SEED)); // R4
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(idReg) && $stable(fcReg) && $stable(addrReg) && $stable(cntReg))); // R8
  AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step) |=> $stable(crcReg)); // R5
endmodule

// File: rtl/mbf_read_framer.sv
module mbf_read_framer
  import mbf_pkg::*;
#(
  parameter logic [15:0] CRC_SEED = 16'hFFFF,
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  slaveId,
  input  logic [7:0]  funcCode,
  input  logic [15:0] startAddr,
  input  logic [15:0] regCount,
  output logic [7:0]  outData,
  output logic        outValid,
  input  logic        outReady,
  output logic        frameDone
);
  mbfCtrl_t ctrl;

  mbf_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .outReady(outReady),
    .outValid(outValid), .frameDone(frameDone), .ctrl(ctrl)
  );

  mbf_datapath #(.CRC_SEED(CRC_SEED), .CRC_POLY(CRC_POLY)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .slaveId(slaveId),
    .funcCode(funcCode), .startAddr(startAddr), .regCount(regCount),
    .outData(outData)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R6
endmodule

// File: tb/sim_mbf_read_framer.sv
`timescale 1ns/1ps
module sim_mbf_read_framer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] slaveId = '0;
  logic [7:0] funcCode = '0;
  logic [15:0] startAddr = '0;
  logic [15:0] regCount = '0;
  logic outReady = 1'b0;
  logic [7:0] outData;
  logic outValid;
  logic frameDone;

  int nChecks = 0;
  int nFails = 0;
  int cycleCnt = 0;
  logic [7:0] gotBytes [8];
  int gotCycles;

  always #10 clk = ~clk;

  mbf_read_framer u0 (
    .clk(clk), .rstN(rstN), .start(start), .slaveId(slaveId),
    .funcCode(funcCode), .startAddr(startAddr), .regCount(regCount),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .frameDone(frameDone)
  );

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt >= 100000) begin
      nFails++;
      $display("FAIL watchdog: act %0d cycles exp < 100000", cycleCnt);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [7:0] b [6]);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[0] ^ b[k][j];
        c = c >> 1;
        if (fb) c = c ^ 16'hA001;
      end
    end
    return c;
  endfunction

  // mode 0: ready always; 1: ready every other cycle; 2: ready every third cycle
  task automatic runFrame(input logic [7:0] id, input logic [7:0] fc,
                          input logic [15:0] addr, input logic [15:0] cnt,
                          input int mode, input bit injectStart);
    logic [7:0] exp [8];
    logic [7:0] body [6];
    logic [15:0] crc;
    int n;
    int firstCyc;
    bit prevStall;
    logic [7:0] prevData;
    body[0] = id; body[1] = fc; body[2] = addr[15:8]; body[3] = addr[7:0];
    body[4] = cnt[15:8]; body[5] = cnt[7:0];
    crc = refCrc(body);
    for (int k = 0; k < 6; k++) exp[k] = body[k];
    exp[6] = crc[7:0];
    exp[7] = crc[15:8];

    @(negedge clk);
    slaveId = id; funcCode = fc; startAddr = addr; regCount = cnt;
    start = 1'b1; outReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(outValid === 1'b1, "R2 valid after start", {31'd0, outValid}, 32'd1);
    chk(outData === id, "R2 first byte", {24'd0, outData}, {24'd0, id});

    n = 0; firstCyc = -1; prevStall = 1'b0; prevData = '0;
    for (int cyc = 0; cyc < 200 && n < 8; cyc++) begin
      if (cyc > 0) @(negedge clk);
      start = 1'b0;
      if (injectStart && cyc == 3) begin
        start = 1'b1;
        slaveId = ~id; funcCode = ~fc; startAddr = ~addr; regCount = ~cnt;
      end
      if (prevStall) begin
        chk(outValid === 1'b1, "R6 valid held", {31'd0, outValid}, 32'd1);
        chk(outData === prevData, "R6 data held", {24'd0, outData}, {24'd0, prevData});
      end
      case (mode)
        0: outReady = 1'b1;
        1: outReady = (cyc % 2) == 1;
        default: outReady = (cyc % 3) == 2;
      endcase
      prevStall = outValid && !outReady;
      prevData = outData;
      if (outValid && outReady) begin
        if (firstCyc < 0) firstCyc = cyc;
        gotBytes[n] = outData;
        n++;
        gotCycles = cyc - firstCyc + 1;
      end
    end
    chk(n == 8, "R5 byte count", n, 8);
    for (int k = 0; k < 8; k++) begin
      string tag;
      tag = (k < 2) ? "R2 byte" : (k < 4) ? "R3 addr byte" : (k < 6) ? "R10 count byte" : "R5 crc byte";
      chk(gotBytes[k] === exp[k], $sformatf("%s %0d", tag, k), {24'd0, gotBytes[k]}, {24'd0, exp[k]});
    end
    if (mode == 0) chk(gotCycles == 8, "R9 back-to-back cycles", gotCycles, 8);
    @(negedge clk);
    start = 1'b0; outReady = 1'b0;
    chk(frameDone === 1'b1, "R7 done pulse", {31'd0, frameDone}, 32'd1);
    chk(outValid === 1'b0, "R7 valid low at done", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    chk(frameDone === 1'b0, "R7 done one cycle", {31'd0, frameDone}, 32'd0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(outValid === 1'b0, "R1 valid in reset", {31'd0, outValid}, 32'd0);
    chk(frameDone === 1'b0, "R1 done in reset", {31'd0, frameDone}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid === 1'b0, "R1 valid after reset", {31'd0, outValid}, 32'd0);
    chk(frameDone === 1'b0, "R1 done after reset", {31'd0, frameDone}, 32'd0);
  endtask

  task automatic testExample();
    runFrame(8'h02, 8'h03, 16'h0010, 16'h0003, 0, 1'b0);
    // R4 R5: fixed example CRC 0x3D04 sent as 04 then 3D
    chk(gotBytes[6] === 8'h04, "R4 example crc low", {24'd0, gotBytes[6]}, 32'h04);
    chk(gotBytes[7] === 8'h3D, "R4 example crc high", {24'd0, gotBytes[7]}, 32'h3D);
  endtask

  initial begin
    testReset();
    testExample();
    runFrame(8'h11, 8'h03, 16'hFFFF, 16'h007D, 1, 1'b0);   // stalls, R10
    runFrame(8'hF7, 8'h04, 16'h1234, 16'h0001, 2, 1'b1);   // busy start, R8
    runFrame(8'h00, 8'h03, 16'h0000, 16'h0000, 0, 1'b0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule